// File: doc/BRIEF.md
# Sticky Fault Status Register

This block holds the sticky cause flags for the local fault classes of a small processor core in one 32-bit register. The core raises single-cycle event pulses when it detects a fault, and each pulse sets its own flag. A flag stays set until software clears it. The register has three sub-fields. The memory-management flags are in byte 0, the bus-fault flags are in byte 1, and the usage-fault flags are in the upper halfword. Two usage-fault sources pass through trap-enable controls. The first is divide-by-zero. The second is unaligned access, but only for single transfers.

Software reaches the register through a simple combinational bus port that supports byte, halfword and word accesses. A read returns the selected sub-register right-aligned. A write clears each flag bit that it carries as a 1. The bus port rejects any size and offset pair it does not support with an error response.

Top module: `fault_status_reg`

## Requirements
- R1: After synchronous reset, all 32 register bits read as 0.
- R2: Bits 2, 5, 6, 13, 14, 20 to 23 and 26 to 31 always read 0, and no event or write can set them.
- R3: One clock edge after an event pulse, its flag reads 1, and it stays 1 until it is cleared. The bit positions are:
  - Memory-management byte: 0 instruction-access violation, 1 data-access violation, 3 unstack error, 4 stack error, 7 memory address valid.
  - Bus-fault byte: 8 instruction bus error, 9 precise data bus error, 10 imprecise bus error, 11 bus unstack error, 12 bus stack error, 15 bus address valid.
  - Usage-fault half: 16 undefined opcode, 17 bad state, 18 bad PC load, 19 no coprocessor, 24 misaligned access, 25 divide by zero.
- R4: A valid write clears each addressed flag bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: When an event and a clearing write hit the same bit on the same edge, the bit ends at 1.
- R6: The bus size code is 00 byte, 01 halfword, 10 word. The supported pairs are:
  - word at offset 0 reaches bytes 0 to 3;
  - halfword at offset 0 reaches bytes 0 and 1;
  - byte at offset 0 reaches byte 0;
  - byte at offset 1 reaches byte 1;
  - halfword at offset 2 reaches bytes 2 and 3.
- R7: Read data is combinational. It holds the addressed bytes shifted down to bit 0, with every other bit 0. Write data is taken right-aligned in the same way.
- R8: Any other size and offset pair, and size code 11, raises bus_err, returns zero read data, and leaves every flag unchanged.
- R9: A divide-by-zero pulse sets bit 25 only when trap_div_en is 1. Otherwise the pulse is ignored.
- R10: A single misaligned access sets bit 24 only when trap_unalign_en is 1. A misaligned multi-word access sets bit 24 whatever that enable is.
- R11: A write leaves unchanged every byte lane outside its addressed lanes.
- R12: Flags accumulate. Events on different bits, in one cycle or in several, leave all of those bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write-one-to-clear, 0 = read |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word |
| bus_offset | input | 2 | Byte offset inside the register |
| bus_wdata | input | 32 | Right-aligned clear mask |
| bus_rdata | output | 32 | Right-aligned read data |
| bus_err | output | 1 | Unsupported access response |
| trap_div_en | input | 1 | Enables the divide-by-zero flag |
| trap_unalign_en | input | 1 | Enables the misaligned flag for single accesses |
| flt_iacc_viol | input | 1 | Instruction-access violation pulse |
| flt_dacc_viol | input | 1 | Data-access violation pulse |
| flt_mm_unstack | input | 1 | Memory-management unstack error pulse |
| flt_mm_stack | input | 1 | Memory-management stack error pulse |
| flt_mm_addr_ok | input | 1 | Memory fault address valid pulse |
| flt_ibus | input | 1 | Instruction bus error pulse |
| flt_dbus_precise | input | 1 | Precise data bus error pulse |
| flt_dbus_imprecise | input | 1 | Imprecise data bus error pulse |
| flt_bus_unstack | input | 1 | Bus unstack error pulse |
| flt_bus_stack | input | 1 | Bus stack error pulse |
| flt_bus_addr_ok | input | 1 | Bus fault address valid pulse |
| flt_undef_op | input | 1 | Undefined opcode pulse |
| flt_bad_state | input | 1 | Bad execution state pulse |
| flt_bad_pc_load | input | 1 | Illegal PC load pulse |
| flt_no_copro | input | 1 | Coprocessor instruction pulse |
| flt_misalign_single | input | 1 | Misaligned single access pulse |
| flt_misalign_multi | input | 1 | Misaligned multi-word access pulse |
| flt_div_zero | input | 1 | Divide-by-zero pulse |

## Verification
The assertions check these properties on every cycle:
- reserved bits stay 0;
- no set flag is lost unless a clear hit it;
- a set always wins over a clear on the same edge;
- a rejected access leaves the flags unchanged;
- the trap gating holds.

Only the bench scenarios can show that each event lands on its documented bit, that each supported access size moves the right bytes to bit 0, and that writes leave bytes outside the addressed lanes untouched. Random traffic that mixes events, clears and all size and offset pairs is compared against a reference model in the bench.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int REG_W  = 32;
    localparam int LANES  = REG_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // flag positions
    localparam int B_IACC     = 0;
    localparam int B_DACC     = 1;
    localparam int B_MUNSTK   = 3;
    localparam int B_MSTK     = 4;
    localparam int B_MM_AV    = 7;
    localparam int B_IBUS     = 8;
    localparam int B_PRECISE  = 9;
    localparam int B_IMPREC   = 10;
    localparam int B_BUNSTK   = 11;
    localparam int B_BSTK     = 12;
    localparam int B_BF_AV    = 15;
    localparam int B_UNDEF    = 16;
    localparam int B_INVSTATE = 17;
    localparam int B_INVPC    = 18;
    localparam int B_NOCP     = 19;
    localparam int B_UNALIGN  = 24;
    localparam int B_DIVZERO  = 25;

    localparam logic [REG_W-1:0] IMPL_MASK = 32'h030F_9F9B;

    typedef struct packed {
        logic iacc;
        logic dacc;
        logic munstk;
        logic mstk;
        logic mm_av;
        logic ibus;
        logic precise;
        logic imprecise;
        logic bunstk;
        logic bstk;
        logic bf_av;
        logic undef;
        logic invstate;
        logic invpc;
        logic nocp;
        logic ua_single;
        logic ua_multi;
        logic divzero;
    } fault_ev_t;

    typedef struct packed {
        logic div_trap;
        logic ua_trap;
    } trap_ctl_t;

    typedef struct packed {
        logic [LANES-1:0] lanes;
        logic [OFF_W-1:0] shift_bytes;
        logic             err;
    } acc_dec_t;

    function automatic logic [REG_W-1:0] lane_bits(input logic [LANES-1:0] lanes);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{lanes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/fsr_event_map.sv
module fsr_event_map
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fault_ev_t        ev,
    input  trap_ctl_t        trap,
    output logic [REG_W-1:0] set_vec
);

    always_comb begin
        set_vec             = '0;
        set_vec[B_IACC]     = ev.iacc;
        set_vec[B_DACC]     = ev.dacc;
        set_vec[B_MUNSTK]   = ev.munstk;
        set_vec[B_MSTK]     = ev.mstk;
        set_vec[B_MM_AV]    = ev.mm_av;
        set_vec[B_IBUS]     = ev.ibus;
        set_vec[B_PRECISE]  = ev.precise;
        set_vec[B_IMPREC]   = ev.imprecise;
        set_vec[B_BUNSTK]   = ev.bunstk;
        set_vec[B_BSTK]     = ev.bstk;
        set_vec[B_BF_AV]    = ev.bf_av;
        set_vec[B_UNDEF]    = ev.undef;
        set_vec[B_INVSTATE] = ev.invstate;
        set_vec[B_INVPC]    = ev.invpc;
        set_vec[B_NOCP]     = ev.nocp;
        // multi-word misalignment always traps; single only when enabled
        set_vec[B_UNALIGN]  = ev.ua_multi | (ev.ua_single & trap.ua_trap);
        set_vec[B_DIVZERO]  = ev.divzero & trap.div_trap;
    end

    // R9: an untrapped divide never raises its flag request
    a_r9_div_gated: assert property (@(posedge clk) disable iff (rst)
        (ev.divzero && !trap.div_trap && !ev.ua_multi) |-> !set_vec[B_DIVZERO]);

    // R10: multi-word misalignment is never filtered
    a_r10_multi_always: assert property (@(posedge clk) disable iff (rst)
        ev.ua_multi |-> set_vec[B_UNALIGN]);

endmodule

// File: rtl/fsr_access_decode.sv
module fsr_access_decode
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] offset,
    output acc_dec_t         dec
);

    always_comb begin
        dec = '{lanes: '0, shift_bytes: '0, err: 1'b0};
        if (valid) begin
            unique case ({size, offset})
                {SZ_WORD, 2'd0}: dec.lanes = 4'b1111;
                {SZ_HALF, 2'd0}: dec.lanes = 4'b0011;
                {SZ_BYTE, 2'd0}: dec.lanes = 4'b0001;
                {SZ_BYTE, 2'd1}: begin
                    dec.lanes       = 4'b0010;
                    dec.shift_bytes = 2'd1;
                end
                {SZ_HALF, 2'd2}: begin
                    dec.lanes       = 4'b1100;
                    dec.shift_bytes = 2'd2;
                end
                default: dec.err = 1'b1;
            endcase
        end
    end

    // R6/R8: every valid access either selects lanes or is rejected
    a_r6_lanes_or_err: assert property (@(posedge clk) disable iff (rst)
        valid |-> (dec.err != (dec.lanes != '0)));

endmodule

// File: rtl/fsr_flag_bank.sv
module fsr_flag_bank
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            // clear first, then set: a coincident fault survives
            flags <= ((flags & ~clr_vec) | set_vec) & IMPL_MASK;
        end
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (flags & ~IMPL_MASK) == '0);

    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(flags) & ~$past(clr_vec) & ~flags) == '0));

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_vec) & IMPL_MASK & ~flags) == '0));

endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
    import fsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [1:0]  bus_size,
    input  logic [1:0]  bus_offset,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    input  logic        trap_div_en,
    input  logic        trap_unalign_en,
    input  logic        flt_iacc_viol,
    input  logic        flt_dacc_viol,
    input  logic        flt_mm_unstack,
    input  logic        flt_mm_stack,
    input  logic        flt_mm_addr_ok,
    input  logic        flt_ibus,
    input  logic        flt_dbus_precise,
    input  logic        flt_dbus_imprecise,
    input  logic        flt_bus_unstack,
    input  logic        flt_bus_stack,
    input  logic        flt_bus_addr_ok,
    input  logic        flt_undef_op,
    input  logic        flt_bad_state,
    input  logic        flt_bad_pc_load,
    input  logic        flt_no_copro,
    input  logic        flt_misalign_single,
    input  logic        flt_misalign_multi,
    input  logic        flt_div_zero
);

    fault_ev_t        ev;
    trap_ctl_t        trap;
    acc_dec_t         dec;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] flags;
    logic [REG_W-1:0] sel_mask;
    logic             wr_ok;

    assign ev = '{
        iacc: flt_iacc_viol,        dacc: flt_dacc_viol,
        munstk: flt_mm_unstack,     mstk: flt_mm_stack,
        mm_av: flt_mm_addr_ok,      ibus: flt_ibus,
        precise: flt_dbus_precise,  imprecise: flt_dbus_imprecise,
        bunstk: flt_bus_unstack,    bstk: flt_bus_stack,
        bf_av: flt_bus_addr_ok,     undef: flt_undef_op,
        invstate: flt_bad_state,    invpc: flt_bad_pc_load,
        nocp: flt_no_copro,         ua_single: flt_misalign_single,
        ua_multi: flt_misalign_multi, divzero: flt_div_zero
    };

    assign trap = '{div_trap: trap_div_en, ua_trap: trap_unalign_en};

    fsr_event_map u_evmap (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .trap    (trap),
        .set_vec (set_vec)
    );

    fsr_access_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .valid  (bus_valid),
        .size   (acc_size_e'(bus_size)),
        .offset (bus_offset),
        .dec    (dec)
    );

    assign sel_mask = lane_bits(dec.lanes);
    assign wr_ok    = bus_valid & bus_write & ~dec.err;
    assign clr_vec  = wr_ok ? ((bus_wdata << {dec.shift_bytes, 3'b000}) & sel_mask)
                            : '0;

    fsr_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    assign bus_err   = dec.err;
    assign bus_rdata = (bus_valid && !bus_write && !dec.err)
                     ? ((flags & sel_mask) >> {dec.shift_bytes, 3'b000})
                     : '0;

    a_r8_err_no_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_err)
        |=> (flags == (($past(flags) | $past(set_vec)) & IMPL_MASK)));

    a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !bus_err && bus_size == 2'b00)
        |-> (bus_rdata[31:8] == '0));

    a_r4_write_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && !bus_err)
        |=> ((flags & $past(clr_vec) & ~$past(set_vec)) == '0));

endmodule

// File: tb/sim_fault_status_reg.sv
`timescale 1ns/1ps
module sim_fault_status_reg;

    localparam logic [31:0] IMPL = 32'h030F_9F9B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = 2'b0, bus_offset = 2'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        tdiv = 1'b0, tua = 1'b0;
    logic [17:0] ev = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] model = '0;

    always #2 clk = ~clk;

    fault_status_reg u0 (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_offset(bus_offset),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .trap_div_en(tdiv), .trap_unalign_en(tua),
        .flt_iacc_viol(ev[0]), .flt_dacc_viol(ev[1]),
        .flt_mm_unstack(ev[2]), .flt_mm_stack(ev[3]),
        .flt_mm_addr_ok(ev[4]), .flt_ibus(ev[5]),
        .flt_dbus_precise(ev[6]), .flt_dbus_imprecise(ev[7]),
        .flt_bus_unstack(ev[8]), .flt_bus_stack(ev[9]),
        .flt_bus_addr_ok(ev[10]), .flt_undef_op(ev[11]),
        .flt_bad_state(ev[12]), .flt_bad_pc_load(ev[13]),
        .flt_no_copro(ev[14]), .flt_misalign_single(ev[15]),
        .flt_misalign_multi(ev[16]), .flt_div_zero(ev[17])
    );

    // event index -> flag position, from the R3 table
    function automatic int ev_pos(input int i);
        case (i)
            0: return 0;   1: return 1;   2: return 3;   3: return 4;
            4: return 7;   5: return 8;   6: return 9;   7: return 10;
            8: return 11;  9: return 12;  10: return 15; 11: return 16;
            12: return 17; 13: return 18; 14: return 19; 15: return 24;
            16: return 24; default: return 25;
        endcase
    endfunction

    function automatic logic [31:0] exp_set(input logic [17:0] e, input logic d, input logic u);
        logic [31:0] s = '0;
        for (int i = 0; i < 15; i++) if (e[i]) s[ev_pos(i)] = 1'b1;
        if (e[16] || (e[15] && u)) s[24] = 1'b1;
        if (e[17] && d) s[25] = 1'b1;
        return s;
    endfunction

    // returns lane bit mask, shift (bytes) and error per R6/R8
    function automatic void exp_dec(input logic [1:0] sz, input logic [1:0] off,
                                    output logic [31:0] m, output int sh, output bit er);
        m = '0; sh = 0; er = 0;
        if (sz == 2'b10 && off == 0) m = 32'hFFFF_FFFF;
        else if (sz == 2'b01 && off == 0) m = 32'h0000_FFFF;
        else if (sz == 2'b00 && off == 0) m = 32'h0000_00FF;
        else if (sz == 2'b00 && off == 1) begin m = 32'h0000_FF00; sh = 1; end
        else if (sz == 2'b01 && off == 2) begin m = 32'hFFFF_0000; sh = 2; end
        else er = 1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one clock of events plus optional write; model updated after the edge
    task automatic step(input logic [17:0] e, input logic d, input logic u,
                        input bit wr, input logic [1:0] sz, input logic [1:0] off,
                        input logic [31:0] wd);
        logic [31:0] m, clr;
        int sh; bit er;
        @(negedge clk);
        ev = e; tdiv = d; tua = u;
        bus_valid = wr; bus_write = wr; bus_size = sz; bus_offset = off; bus_wdata = wd;
        exp_dec(sz, off, m, sh, er);
        clr = (wr && !er) ? ((wd << (8*sh)) & m) : '0;
        @(posedge clk);
        #1;
        model = ((model & ~clr) | exp_set(e, d, u)) & IMPL;
        ev = '0; bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input string req, input logic [1:0] sz, input logic [1:0] off);
        logic [31:0] m;
        int sh; bit er;
        @(negedge clk);
        ev = '0; bus_valid = 1; bus_write = 0; bus_size = sz; bus_offset = off;
        exp_dec(sz, off, m, sh, er);
        #1;
        chk(req, bus_rdata, er ? 32'h0 : ((model & m) >> (8*sh)));
        chk(req, {31'b0, bus_err}, {31'b0, er});
        bus_valid = 0;
    endtask

    task automatic clear_all();
        step('0, 0, 0, 1, 2'b10, 2'b00, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7319));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rd("R1", 2'b10, 2'b00);
        chk("R1", model, 32'h0);

        // R3 each event lands on its bit (traps on)
        for (int i = 0; i < 18; i++) begin
            step(18'(1) << i, 1, 1, 0, 0, 0, 0);
            rd("R3", 2'b10, 2'b00);
            chk("R3", bus_rdata, 32'h1 << ev_pos(i));
            step('0, 0, 0, 0, 0, 0, 0);
            rd("R3", 2'b10, 2'b00);
            clear_all();
            rd("R4", 2'b10, 2'b00);
        end

        // R9 gated divide, R10 misalignment gating
        step(18'(1) << 17, 0, 1, 0, 0, 0, 0);
        rd("R9", 2'b10, 2'b00); chk("R9", bus_rdata, 32'h0);
        step(18'(1) << 15, 1, 0, 0, 0, 0, 0);
        rd("R10", 2'b10, 2'b00); chk("R10", bus_rdata, 32'h0);
        step(18'(1) << 16, 0, 0, 0, 0, 0, 0);
        rd("R10", 2'b10, 2'b00); chk("R10", bus_rdata, 32'h0100_0000);
        clear_all();

        // R12 and R2: every event at once, plus accumulation over cycles
        step(18'h3FFFF, 1, 1, 0, 0, 0, 0);
        rd("R2", 2'b10, 2'b00); chk("R12", bus_rdata, IMPL);
        clear_all();
        step(18'h1, 0, 0, 0, 0, 0, 0);
        step(18'h20, 0, 0, 0, 0, 0, 0);
        rd("R12", 2'b10, 2'b00); chk("R12", bus_rdata, 32'h0000_0101);

        // R4 write of zeros leaves flags
        step('0, 0, 0, 1, 2'b10, 2'b00, 32'h0);
        rd("R4", 2'b10, 2'b00); chk("R4", bus_rdata, 32'h0000_0101);

        // R5 set and clear on the same bit and edge
        step(18'h1, 0, 0, 1, 2'b00, 2'b00, 32'hFF);
        rd("R5", 2'b10, 2'b00); chk("R5", bus_rdata, 32'h0000_0101);
        clear_all();

        // R6/R7 all sizes with a full pattern; R11 lane isolation
        step(18'h3FFFF, 1, 1, 0, 0, 0, 0);
        rd("R6", 2'b00, 2'b00); rd("R6", 2'b00, 2'b01);
        rd("R7", 2'b01, 2'b00); rd("R7", 2'b01, 2'b10);
        step('0, 0, 0, 1, 2'b00, 2'b01, 32'hFFFF_FFFF);
        rd("R11", 2'b10, 2'b00); chk("R11", bus_rdata, 32'h030F_009B);
        step('0, 0, 0, 1, 2'b01, 2'b10, 32'h0000_0001);
        rd("R11", 2'b10, 2'b00); chk("R11", bus_rdata, 32'h030E_009B);

        // R8 unsupported pairs: error, no effect
        for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 4; off++) begin
                logic [31:0] m; int sh; bit er;
                exp_dec(2'(sz), 2'(off), m, sh, er);
                if (er) begin
                    step('0, 0, 0, 1, 2'(sz), 2'(off), 32'hFFFF_FFFF);
                    rd("R8", 2'(sz), 2'(off));
                    rd("R8", 2'b10, 2'b00); chk("R8", bus_rdata, 32'h030E_009B);
                end
            end

        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [17:0] e;
            e = 18'($urandom & $urandom & $urandom);
            step(e, 1'($urandom), 1'($urandom), bit'($urandom % 2),
                 2'($urandom), 2'($urandom), $urandom);
            rd("R4", 2'b10, 2'b00);
            rd("R6", 2'($urandom), 2'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule